// File: doc/BRIEF.md
# Pulse High/Low Period Meter

This block measures a slow digital pulse train against a fast local timebase. It reports how long the input stayed high and how long it stayed low, each as a count of timebase ticks. The input is asynchronous to the clock, so it is first brought into the clock domain through a short flop chain. A transition is then found by comparing the newest synchronized sample with the one before it.

Two saturating counters run side by side. The high-period counter starts again from zero at every rising transition, and the low-period counter starts again at every falling transition. When a falling transition arrives, the high-period counter's value is copied into the high result register. When a rising transition arrives, the low-period counter's value is copied into the low result register. A one-clock update strobe marks each copy. Both the frequency and the duty cycle can be derived from the two results, and both follow the input within one period.

A tick enable lets the timebase be slower than the clock. A validity flag reports when both results hold real measurements. Resolution is one tick, and input jitter shows up directly in the counts.

Top module: `pulse_meter`

## Requirements
- R1: A level change on `sig_in` that is set up before clock edge n produces its update strobe and new result in the cycle after edge n+SYNC_STAGES. No earlier edge and no later edge produces it.
- R2: At each falling transition, `hi_cnt_o` takes the number of clocks with `tick_en` high over the high interval. That interval starts with the restart edge and ends just before the capture edge, and its count is shifted by the synchronizer delay.
- R3: At each rising transition, `lo_cnt_o` takes the matching count for the low interval, measured in the same way as in R2.
- R4: The counts saturate at 2^CNT_W-1 and never wrap, so an input held at one level for too long reads as full scale.
- R5: A counter advances only on clocks with `tick_en` high. If `tick_en` stays low for a whole interval, the captured value is 0.
- R6: `upd_o` is high for exactly one clock per input transition, in the same cycle the new value first appears. Between strobes, both results hold steady.
- R7: `valid_o` is low after reset until at least one rising capture and one falling capture have both occurred. It rises together with the strobe that completes that pair and then stays high until the next reset.
- R8: Asserting `rst_n` low clears all outputs at once, without waiting for a clock. Release takes effect through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| tick_en | input | 1 | Timebase enable; counters advance only when high |
| sig_in | input | 1 | Asynchronous pulse train to be measured |
| hi_cnt_o | output | CNT_W | Latest captured high-interval length in ticks |
| lo_cnt_o | output | CNT_W | Latest captured low-interval length in ticks |
| upd_o | output | 1 | One-clock strobe marking a new captured value |
| valid_o | output | 1 | Both results hold a real measurement |

## Verification
The bench builds the meter with CNT_W=6 and SYNC_STAGES=2. A 6-bit count reaches full scale after 63 ticks, so held levels of 100 to 150 clocks exercise saturation in a short run. The unchanged synchronizer depth fixes the strobe latency at three edges after the input change. Tick-enable patterns (always on, every third clock, an irregular mask, and always off) are combined with random interval lengths down to a single clock. This lets the bench check the counts themselves, the back-to-back transitions and the zero-count case, as well as a reset asserted in mid-run.

// File: rtl/pulse_meter_pkg.sv
package pulse_meter_pkg;

  // Classification of the synchronized input in the current cycle.
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2
  } edge_kind_e;

  // Index of each run counter inside the counter array.
  localparam int RUN_HIGH = 0;
  localparam int RUN_LOW  = 1;
  localparam int RUN_NUM  = 2;

endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_int_n = chain_q[STAGES-1];

endmodule

// File: rtl/pm_edge_sync.sv
module pm_edge_sync
  import pulse_meter_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig_in,
  output edge_kind_e edge_kind
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], sig_in};
    prev_d = sync_q[TOP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    if (sync_q[TOP] && !prev_q) begin
      edge_kind = EDGE_RISE;
    end else if (!sync_q[TOP] && prev_q) begin
      edge_kind = EDGE_FALL;
    end else begin
      edge_kind = EDGE_NONE;
    end
  end

endmodule

// File: rtl/pm_sat_counter.sv
module pm_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             restart,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;

  // The restart cycle is the first cycle of the new interval, so its tick counts.
  always_comb begin
    count_d = count_q;
    if (restart) begin
      count_d = tick_en ? CNT_ONE : '0;
    end else if (tick_en && (count_q != CNT_MAX)) begin
      count_d = count_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/pm_capture.sv
module pm_capture
  import pulse_meter_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  edge_kind_e       edge_kind,
  input  logic [CNT_W-1:0] hi_run,
  input  logic [CNT_W-1:0] lo_run,
  output logic [CNT_W-1:0] hi_hold_o,
  output logic [CNT_W-1:0] lo_hold_o,
  output logic             upd_o,
  output logic             valid_o
);

  logic [CNT_W-1:0] hi_hold_q, hi_hold_d;
  logic [CNT_W-1:0] lo_hold_q, lo_hold_d;
  logic             upd_q, upd_d;
  logic             seen_rise_q, seen_rise_d;
  logic             seen_fall_q, seen_fall_d;
  logic             hi_load, lo_load;

  // A falling transition closes the high interval, a rising one the low interval.
  always_comb begin
    hi_load     = (edge_kind == EDGE_FALL);
    lo_load     = (edge_kind == EDGE_RISE);
    hi_hold_d   = hi_load ? hi_run : hi_hold_q;
    lo_hold_d   = lo_load ? lo_run : lo_hold_q;
    upd_d       = hi_load || lo_load;
    seen_rise_d = seen_rise_q || lo_load;
    seen_fall_d = seen_fall_q || hi_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_hold_q   <= '0;
      lo_hold_q   <= '0;
      upd_q       <= 1'b0;
      seen_rise_q <= 1'b0;
      seen_fall_q <= 1'b0;
    end else begin
      if (hi_load) begin
        hi_hold_q <= hi_hold_d;
      end
      if (lo_load) begin
        lo_hold_q <= lo_hold_d;
      end
      upd_q       <= upd_d;
      seen_rise_q <= seen_rise_d;
      seen_fall_q <= seen_fall_d;
    end
  end

  assign hi_hold_o = hi_hold_q;
  assign lo_hold_o = lo_hold_q;
  assign upd_o     = upd_q;
  assign valid_o   = seen_rise_q && seen_fall_q;

endmodule

// File: rtl/pulse_meter.sv
module pulse_meter
  import pulse_meter_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             sig_in,
  output logic [CNT_W-1:0] hi_cnt_o,
  output logic [CNT_W-1:0] lo_cnt_o,
  output logic             upd_o,
  output logic             valid_o
);

  localparam int RST_STAGES = 2;

  logic             rst_int_n;
  edge_kind_e       edge_kind;
  logic [RUN_NUM-1:0] restart_vec;
  logic [CNT_W-1:0] run_cnt [RUN_NUM];

  pm_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  pm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sig_in    (sig_in),
    .edge_kind (edge_kind)
  );

  // The high-interval counter restarts on a rise, the low-interval one on a fall.
  always_comb begin
    restart_vec           = '0;
    restart_vec[RUN_HIGH] = (edge_kind == EDGE_RISE);
    restart_vec[RUN_LOW]  = (edge_kind == EDGE_FALL);
  end

  for (genvar g = 0; g < RUN_NUM; g++) begin : g_run
    pm_sat_counter #(.CNT_W(CNT_W)) u_run (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .tick_en (tick_en),
      .restart (restart_vec[g]),
      .count_o (run_cnt[g])
    );
  end

  pm_capture #(.CNT_W(CNT_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .edge_kind (edge_kind),
    .hi_run    (run_cnt[RUN_HIGH]),
    .lo_run    (run_cnt[RUN_LOW]),
    .hi_hold_o (hi_cnt_o),
    .lo_hold_o (lo_cnt_o),
    .upd_o     (upd_o),
    .valid_o   (valid_o)
  );

endmodule

// File: rtl/pulse_meter_chk.sv
module pulse_meter_chk
  import pulse_meter_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             tick_en,
  input edge_kind_e       edge_kind,
  input logic [CNT_W-1:0] hi_run,
  input logic [CNT_W-1:0] lo_run,
  input logic [CNT_W-1:0] hi_cnt_o,
  input logic [CNT_W-1:0] lo_cnt_o,
  input logic             upd_o,
  input logic             valid_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R4: a full-scale counter stays full scale until its own restart.
  p_hi_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (hi_run == CNT_MAX && edge_kind != EDGE_RISE) |=> hi_run == CNT_MAX);

  p_lo_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lo_run == CNT_MAX && edge_kind != EDGE_FALL) |=> lo_run == CNT_MAX);

  // R5: without a tick and without a restart, neither counter moves.
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!tick_en && edge_kind == EDGE_NONE) |=> ($stable(hi_run) && $stable(lo_run)));

  // R2: a rising transition starts the high interval at zero or one tick.
  p_hi_restart_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (edge_kind == EDGE_RISE) |=> hi_run <= CNT_W'(1));

  // R3: a falling transition starts the low interval at zero or one tick.
  p_lo_restart_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (edge_kind == EDGE_FALL) |=> lo_run <= CNT_W'(1));

  // R6: a strobe always follows a detected transition.
  p_upd_cause_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    upd_o |-> $past(edge_kind != EDGE_NONE));

  // R6: results never change without a strobe.
  p_hold_steady_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !upd_o |-> ($stable(hi_cnt_o) && $stable(lo_cnt_o)));

  // R7: validity is sticky and only appears with a strobe.
  p_valid_sticky_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    valid_o |=> valid_o);

  p_valid_rise_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(valid_o) |-> upd_o);

endmodule

bind pulse_meter pulse_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .tick_en   (tick_en),
  .edge_kind (edge_kind),
  .hi_run    (run_cnt[0]),
  .lo_run    (run_cnt[1]),
  .hi_cnt_o  (hi_cnt_o),
  .lo_cnt_o  (lo_cnt_o),
  .upd_o     (upd_o),
  .valid_o   (valid_o)
);

// File: tb/pulse_meter_bench.sv
module pulse_meter_bench;

  localparam int CW   = 6;
  localparam int SY   = 2;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk;
  logic          rst_n;
  logic          tick_en;
  logic          sig_in;
  logic [CW-1:0] hi_cnt_o;
  logic [CW-1:0] lo_cnt_o;
  logic          upd_o;
  logic          valid_o;

  pulse_meter #(.CNT_W(CW), .SYNC_STAGES(SY)) u_pulse_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .sig_in   (sig_in),
    .hi_cnt_o (hi_cnt_o),
    .lo_cnt_o (lo_cnt_o),
    .upd_o    (upd_o),
    .valid_o  (valid_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;
  bit en_log [256];
  int q_due[$];
  int q_start[$];
  bit q_lvl[$];
  bit q_dc[$];
  bit cur_lvl;
  int cur_start;
  bit first_dc;
  bit mon_on = 1'b0;
  int en_mode = 0;
  logic [CW-1:0] last_hi, last_lo;
  bit seen_r, seen_f;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit en_f(input int p, input int mode);
    case (mode)
      0:       return 1'b1;
      1:       return (p % 3) == 0;
      2:       return ((p ^ (p >> 2) ^ (p >> 5)) & 1) == 0;
      default: return 1'b0;
    endcase
  endfunction

  // Enabled ticks over clocks [s, e), capped at full scale.
  function automatic int exp_count(input int s, input int e);
    int acc = 0;
    for (int p = s; p < e; p++) acc += int'(en_log[p % 256]);
    if (acc > MAXV) acc = MAXV;
    return acc;
  endfunction

  task automatic drive_cycle();
    tick_en = en_f(cyc + 1, en_mode);
    en_log[(cyc + 1) % 256] = tick_en;
    @(negedge clk);
  endtask

  task automatic phase(input bit lvl, input int n);
    if (lvl != cur_lvl) begin
      q_start.push_back(cur_start);
      q_due.push_back(cyc + 1 + SY);
      q_lvl.push_back(cur_lvl);
      q_dc.push_back(first_dc);
      first_dc  = 1'b0;
      cur_start = cyc + 1;
      cur_lvl   = lvl;
    end
    sig_in = lvl;
    for (int i = 0; i < n; i++) drive_cycle();
  endtask

  task automatic reinit();
    q_due.delete(); q_start.delete(); q_lvl.delete(); q_dc.delete();
    cur_lvl = 1'b0; cur_start = cyc + 1; first_dc = 1'b1;
    last_hi = '0; last_lo = '0; seen_r = 1'b0; seen_f = 1'b0;
  endtask

  task automatic check_zero(input string what);
    check(hi_cnt_o == '0 && lo_cnt_o == '0, "R8", int'(hi_cnt_o) + int'(lo_cnt_o), 0, {what, " results"});
    check(!upd_o && !valid_o, "R8", int'(upd_o) + int'(valid_o), 0, {what, " strobe/valid"});
  endtask

  // Monitor: compare every clock against the expected capture schedule.
  always @(negedge clk) begin
    if (mon_on) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        int exp;
        string rq;
        check(upd_o == 1'b1, "R1", int'(upd_o), 1, "strobe at expected cycle");
        exp = exp_count(q_start[0] + SY, q_due[0]);
        rq  = (exp == MAXV) ? "R4" : ((exp == 0) ? "R5" : (q_lvl[0] ? "R2" : "R3"));
        if (q_lvl[0]) begin
          if (!q_dc[0]) check(int'(hi_cnt_o) == exp, rq, int'(hi_cnt_o), exp, "high interval");
          check(lo_cnt_o == last_lo, "R6", int'(lo_cnt_o), int'(last_lo), "low result kept");
          last_hi = hi_cnt_o;
          seen_f  = 1'b1;
        end else begin
          if (!q_dc[0]) check(int'(lo_cnt_o) == exp, rq, int'(lo_cnt_o), exp, "low interval");
          check(hi_cnt_o == last_hi, "R6", int'(hi_cnt_o), int'(last_hi), "high result kept");
          last_lo = lo_cnt_o;
          seen_r  = 1'b1;
        end
        void'(q_due.pop_front()); void'(q_start.pop_front());
        void'(q_lvl.pop_front()); void'(q_dc.pop_front());
      end else begin
        check(!upd_o, "R6", int'(upd_o), 0, "no stray strobe");
        check(hi_cnt_o == last_hi && lo_cnt_o == last_lo, "R6",
              int'(hi_cnt_o) * 1000 + int'(lo_cnt_o), int'(last_hi) * 1000 + int'(last_lo), "results steady");
      end
      check(valid_o == (seen_r && seen_f), "R7", int'(valid_o), int'(seen_r && seen_f), "valid flag");
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; tick_en = 1'b0; sig_in = 1'b0;
    repeat (4) @(negedge clk);
    check_zero("in reset");
    rst_n = 1'b1;
    repeat (2) drive_cycle();
    check_zero("after release");
    repeat (2) drive_cycle();
    reinit();
    mon_on = 1'b1;

    // Directed, tick every clock, including one-clock intervals.
    en_mode = 0;
    phase(1, 5); phase(0, 3); phase(1, 1); phase(0, 1); phase(1, 2); phase(0, 7);

    // Random intervals under sparse and irregular tick masks.
    for (int m = 1; m <= 2; m++) begin
      en_mode = m;
      for (int k = 0; k < 40; k++) phase(~cur_lvl, 1 + int'($urandom_range(39)));
    end

    // No ticks: captures read zero.
    en_mode = 3;
    phase(1, 4); phase(0, 6); phase(1, 3); phase(0, 5);

    // Long levels: full scale, then short intervals recover.
    en_mode = 0;
    phase(1, 150); phase(0, 100); phase(1, 3); phase(0, 3); phase(1, 64); phase(0, 63);
    phase(1, 4); phase(0, 10);

    // Asynchronous reset in mid-run.
    phase(1, 6);
    mon_on = 1'b0;
    #1 rst_n = 1'b0;
    #1 check_zero("async assert");
    sig_in = 1'b0;
    repeat (3) drive_cycle();
    check_zero("held reset");
    rst_n = 1'b1;
    repeat (4) drive_cycle();
    check_zero("second release");
    reinit();
    mon_on = 1'b1;
    phase(1, 8); phase(0, 5); phase(1, 2); phase(0, 12);

    check(q_due.size() == 0, "R6", q_due.size(), 0, "pending captures");
    done = 1'b1;
    finish_run();
  end

endmodule